// File: doc/BRIEF.md
# Programmable Pattern-Match Logic Array

This block holds a small set of stored patterns in writable registers and compares one input word against all of them at once, driving one output bit per pattern. Each pattern is kept as a value word plus a care-mask word. A format input picks how a pattern is read. In array format only the 1 bits of the value word matter, and the mask is not used. In plane format the value bits whose mask bit is 1 matter, whether they are 0 or 1, and a mask bit of 0 marks a don't-care position.

A second input picks how the significant bit positions are combined: AND (all must match), OR (at least one matches), or the inverted forms NAND and NOR. Patterns are loaded through an address, value, mask and write-enable port, and can be changed while the block runs. An elaboration parameter chooses between outputs that follow the inputs combinationally and outputs registered on the rising clock edge.

Top module: `pla_match_array`

## Requirements
- R1: `match_out` has NUM_PAT bits, and bit i gives the result for stored pattern i only.
- R2: Array format (`fmt_plane`=0) with AND: bit i is 1 exactly when every 1 bit of value word i is also 1 in `data_in`. Extra 1s in `data_in` are allowed.
- R3: Plane format (`fmt_plane`=1) with AND: bit i is 1 exactly when `data_in` equals value word i at every position where mask word i is 1. Positions where the mask is 0 are don't-cares.
- R4: OR mode: bit i is 1 when at least one significant position of pattern i matches the corresponding `data_in` bit. In array format, matching means both are 1.
- R5: `comb_sel` encoding is 2'b00 AND, 2'b01 OR, 2'b10 NAND, 2'b11 NOR. NAND and NOR give the bitwise complement of the AND and OR results.
- R6: A pattern with no significant positions gives 1 under AND and 0 under OR, before any inversion.
- R7: When `wr_en` is high at a rising edge, `wr_value` and `wr_mask` are stored at `wr_addr`. From then on, `match_out` reflects the new contents.
- R8: In array format the mask word has no effect on the result.
- R9: Synchronous reset `rst` clears every value and mask word to 0.
- R10: With REGISTERED=1, `match_out` shows the result computed from the inputs and patterns present at the previous rising edge, and reset forces it to 0. With REGISTERED=0, `match_out` follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fmt_plane | input | 1 | 0 = array format, 1 = plane format |
| comb_sel | input | 2 | Combining logic: 00 AND, 01 OR, 10 NAND, 11 NOR |
| wr_en | input | 1 | Pattern write enable |
| wr_addr | input | ADDR_W | Index of the pattern to write |
| wr_value | input | WIDTH | Value word to store |
| wr_mask | input | WIDTH | Care mask to store (1 = significant in plane format) |
| data_in | input | WIDTH | Input word compared against every pattern |
| match_out | output | NUM_PAT | One result bit per pattern |

## Verification
The bench targets the cases where the two formats disagree. For input 0x3F, array AND reports three patterns while plane AND reports only the don't-care pattern. A design that ignored stored zeros in plane format, or honoured them in array format, would give the other answer. Clearing a mask word checks two things: that array results stay the same, and that plane results treat an all-don't-care pattern as a hit under AND and a miss under OR. A wrong empty-set default or a mask leaking into array mode shows up there. The registered instance is compared one cycle behind the combinational one across back-to-back mode changes, so an off-by-one pipeline, or a register that samples patterns after a write instead of before it, is caught.

// File: rtl/pla_pkg.sv
package pla_pkg;

   typedef enum logic [1:0] {
      COMB_AND  = 2'b00,
      COMB_OR   = 2'b01,
      COMB_NAND = 2'b10,
      COMB_NOR  = 2'b11
   } pla_comb_e;

   function automatic int unsigned addr_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pla_pattern_store.sv
module pla_pattern_store #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned NUM_PAT = 4,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [WIDTH-1:0]                wr_value,
   input  logic [WIDTH-1:0]                wr_mask,
   output logic [NUM_PAT-1:0][WIDTH-1:0]   pat_value,
   output logic [NUM_PAT-1:0][WIDTH-1:0]   pat_mask
);

   logic [NUM_PAT-1:0] row_sel;

   // one-hot row decode, out-of-range addresses select nothing
   always_comb begin
      row_sel = '0;
      for (int unsigned r = 0; r < NUM_PAT; r++) begin
         row_sel[r] = wr_en && (wr_addr == ADDR_W'(r));
      end
   end

   for (genvar g = 0; g < NUM_PAT; g++) begin : g_row
      always_ff @(posedge clk) begin
         if (rst) begin
            pat_value[g] <= '0;
            pat_mask[g]  <= '0;
         end else if (row_sel[g]) begin
            pat_value[g] <= wr_value;
            pat_mask[g]  <= wr_mask;
         end
      end

      // R7
      row_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_addr == ADDR_W'(g)) |=> (pat_value[g] == $past(wr_value)
                                             && pat_mask[g] == $past(wr_mask)));
   end

   // R7: at most one row written per edge
   row_sel_unique_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_sel));

endmodule

// File: rtl/pla_term_eval.sv
module pla_term_eval #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned NUM_PAT = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            fmt_plane,
   input  logic [WIDTH-1:0]                data_in,
   input  logic [NUM_PAT-1:0][WIDTH-1:0]   pat_value,
   input  logic [NUM_PAT-1:0][WIDTH-1:0]   pat_mask,
   output logic [NUM_PAT-1:0]              and_vec,
   output logic [NUM_PAT-1:0]              or_vec
);

   for (genvar g = 0; g < NUM_PAT; g++) begin : g_term
      logic [WIDTH-1:0] signif;
      logic [WIDTH-1:0] bit_eq;

      // array format: stored 1s are the care set; plane: explicit mask
      assign signif = fmt_plane ? pat_mask[g] : pat_value[g];
      assign bit_eq = ~(pat_value[g] ^ data_in);

      assign and_vec[g] = &(bit_eq | ~signif);
      assign or_vec[g]  = |(bit_eq & signif);

      // R6
      empty_term_chk: assert property (@(posedge clk) disable iff (rst)
         (signif == '0) |-> (and_vec[g] && !or_vec[g]));

      // R2
      array_subset_chk: assert property (@(posedge clk) disable iff (rst)
         (!fmt_plane && ((pat_value[g] & ~data_in) == '0)) |-> and_vec[g]);

      // R3
      plane_exact_chk: assert property (@(posedge clk) disable iff (rst)
         (fmt_plane && (&pat_mask[g]) && and_vec[g]) |-> (pat_value[g] == data_in));

      // R4
      and_implies_or_chk: assert property (@(posedge clk) disable iff (rst)
         ((signif != '0) && and_vec[g]) |-> or_vec[g]);
   end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
   parameter int unsigned NUM_PAT    = 4,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_PAT-1:0] d,
   output logic [NUM_PAT-1:0] q
);

   if (REGISTERED) begin : g_sync
      logic [NUM_PAT-1:0] q_r;

      always_ff @(posedge clk) begin
         if (rst) q_r <= '0;
         else     q_r <= d;
      end
      assign q = q_r;

      // R10
      reg_delay_chk: assert property (@(posedge clk) disable iff (rst)
         !rst |=> (q == $past(d)));
   end else begin : g_async
      assign q = d;
   end

endmodule

// File: rtl/pla_match_array.sv
module pla_match_array
   import pla_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned NUM_PAT    = 4,
   parameter bit          REGISTERED = 1'b0,
   localparam int unsigned ADDR_W    = addr_width(NUM_PAT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               fmt_plane,
   input  logic [1:0]         comb_sel,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WIDTH-1:0]   wr_value,
   input  logic [WIDTH-1:0]   wr_mask,
   input  logic [WIDTH-1:0]   data_in,
   output logic [NUM_PAT-1:0] match_out
);

   if (WIDTH < 1)   begin : g_bad_width $error("WIDTH must be at least 1");   end
   if (NUM_PAT < 1) begin : g_bad_npat  $error("NUM_PAT must be at least 1"); end

   logic [NUM_PAT-1:0][WIDTH-1:0] pat_value;
   logic [NUM_PAT-1:0][WIDTH-1:0] pat_mask;
   logic [NUM_PAT-1:0]            and_vec;
   logic [NUM_PAT-1:0]            or_vec;
   logic [NUM_PAT-1:0]            raw;
   pla_comb_e                     mode;

   assign mode = pla_comb_e'(comb_sel);

   pla_pattern_store #(.WIDTH(WIDTH), .NUM_PAT(NUM_PAT), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_value  (wr_value),
      .wr_mask   (wr_mask),
      .pat_value (pat_value),
      .pat_mask  (pat_mask)
   );

   pla_term_eval #(.WIDTH(WIDTH), .NUM_PAT(NUM_PAT)) u_eval (
      .clk       (clk),
      .rst       (rst),
      .fmt_plane (fmt_plane),
      .data_in   (data_in),
      .pat_value (pat_value),
      .pat_mask  (pat_mask),
      .and_vec   (and_vec),
      .or_vec    (or_vec)
   );

   always_comb begin
      unique case (mode)
         COMB_AND:  raw = and_vec;
         COMB_OR:   raw = or_vec;
         COMB_NAND: raw = ~and_vec;
         COMB_NOR:  raw = ~or_vec;
         default:   raw = and_vec;
      endcase
   end

   pla_out_stage #(.NUM_PAT(NUM_PAT), .REGISTERED(REGISTERED)) u_out (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (match_out)
   );

endmodule

// File: tb/test_pla_match_array.sv
module test_pla_match_array;

   localparam int unsigned W  = 8;
   localparam int unsigned NP = 4;
   localparam int unsigned AW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          fmt_plane = 1'b0;
   logic [1:0]    comb_sel = 2'b00;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_value = '0;
   logic [W-1:0]  wr_mask = '0;
   logic [W-1:0]  data_in = '0;
   logic [NP-1:0] out_c;
   logic [NP-1:0] out_r;

   int  n_chk  = 0;
   int  n_fail = 0;
   longint cyc = 0;

   logic [W-1:0] sh_val [NP];
   logic [W-1:0] sh_msk [NP];

   typedef struct {
      logic [NP-1:0] exp;
      string         tag;
      longint        at;
   } item_t;

   item_t q_exp[$];
   item_t prev;
   bit    prev_ok = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   pla_match_array #(.WIDTH(W), .NUM_PAT(NP), .REGISTERED(1'b0)) i_pla_match_array (
      .clk(clk), .rst(rst), .fmt_plane(fmt_plane), .comb_sel(comb_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_value(wr_value), .wr_mask(wr_mask),
      .data_in(data_in), .match_out(out_c));

   pla_match_array #(.WIDTH(W), .NUM_PAT(NP), .REGISTERED(1'b1)) i_pla_match_array_reg (
      .clk(clk), .rst(rst), .fmt_plane(fmt_plane), .comb_sel(comb_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_value(wr_value), .wr_mask(wr_mask),
      .data_in(data_in), .match_out(out_r));

   task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // reference written from the requirements, bit by bit
   function automatic logic [NP-1:0] model(input logic plane, input logic [1:0] sel,
                                           input logic [W-1:0] d);
      logic [NP-1:0] r;
      for (int p = 0; p < NP; p++) begin
         int nsig = 0;
         int nhit = 0;
         for (int b = 0; b < W; b++) begin
            bit sig = plane ? sh_msk[p][b] : sh_val[p][b];
            if (sig) begin
               nsig++;
               if (sh_val[p][b] == d[b]) nhit++;
            end
         end
         r[p] = sel[0] ? (nhit > 0) : (nhit == nsig);
         if (sel[1]) r[p] = ~r[p];
      end
      return r;
   endfunction

   task automatic write_pat(input int a, input logic [W-1:0] v, input logic [W-1:0] m);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = AW'(a); wr_value = v; wr_mask = m;
      @(posedge clk); #1;
      wr_en = 1'b0;
      sh_val[a] = v; sh_msk[a] = m;
   endtask

   // driver: apply stimulus, push expected item
   task automatic apply(input logic plane, input logic [1:0] sel, input logic [W-1:0] d,
                        input logic [NP-1:0] exp, input string tag);
      item_t it;
      @(posedge clk); #1;
      fmt_plane = plane; comb_sel = sel; data_in = d;
      it.exp = exp; it.tag = tag; it.at = cyc;
      q_exp.push_back(it);
   endtask

   task automatic apply_m(input logic plane, input logic [1:0] sel, input logic [W-1:0] d,
                          input string tag);
      apply(plane, sel, d, model(plane, sel, d), tag);
   endtask

   // monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      while (q_exp.size() > 0) begin
         item_t it;
         it = q_exp.pop_front();
         check({it.tag, " comb"}, out_c, it.exp);
         if (prev_ok && prev.at == it.at - 1)
            check({"R10 registered lag after ", prev.tag}, out_r, prev.exp);
         prev = it;
         prev_ok = 1'b1;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int p = 0; p < NP; p++) begin sh_val[p] = '0; sh_msk[p] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: cleared patterns have no significant bits, AND gives all ones
      check("R9 reset clears patterns", out_c, 4'b1111);
      check("R10 registered output zero in reset", out_r, 4'b0000);
      @(posedge clk); #1; rst = 1'b0;

      // R6 empty patterns
      apply(1'b0, 2'b00, 8'h5A, 4'b1111, "R6 empty AND");
      apply(1'b0, 2'b01, 8'h5A, 4'b0000, "R6 empty OR");

      write_pat(0, 8'b11001100, 8'hFF);
      write_pat(1, 8'b00110011, 8'hFF);
      write_pat(2, 8'b00001111, 8'hFF);
      write_pat(3, 8'b00110000, 8'hF0);

      apply(1'b0, 2'b00, 8'h3F, 4'b1110, "R2 array AND extra ones");
      apply(1'b1, 2'b00, 8'h3F, 4'b1000, "R3 plane AND zeros significant");
      apply(1'b0, 2'b00, 8'hCC, 4'b0001, "R1 array AND bit per pattern");
      apply(1'b1, 2'b00, 8'hCC, 4'b0001, "R1 plane AND bit per pattern");
      apply(1'b1, 2'b00, 8'h3A, 4'b1000, "R3 plane AND don't cares");
      apply(1'b1, 2'b00, 8'h0F, 4'b0100, "R3 plane AND exact");
      apply(1'b0, 2'b01, 8'h01, 4'b0110, "R4 array OR");
      apply(1'b1, 2'b01, 8'h00, 4'b1111, "R4 plane OR zero matches");
      apply(1'b0, 2'b10, 8'h3F, 4'b0001, "R5 NAND");
      apply(1'b1, 2'b11, 8'hFF, 4'b0000, "R5 NOR");

      // R8: clearing the mask leaves array results unchanged
      write_pat(3, 8'b00110000, 8'h00);
      apply(1'b0, 2'b00, 8'h3F, 4'b1110, "R8 array ignores mask");
      apply(1'b1, 2'b00, 8'h00, 4'b1000, "R6 plane all don't care AND");
      apply(1'b1, 2'b01, 8'h00, 4'b0111, "R6 plane all don't care OR");

      // R7 runtime rewrite
      write_pat(0, 8'h00, 8'hFF);
      apply(1'b1, 2'b00, 8'h00, 4'b1001, "R7 rewritten pattern");

      // sweep all modes back to back (exercises R10 lag too)
      for (int k = 0; k < 24; k++) begin
         logic [W-1:0] d = W'(k * 37 + 11);
         apply_m(k[0], k[2:1], d, "R1 sweep");
      end

      @(negedge clk); @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule